// File: doc/BRIEF.md
# Single-Bit Manipulation Execute Unit

This block decodes and executes the four single-bit operations of a 64-bit integer pipeline in one combinational pass. The four operations are set, clear, invert and extract. It takes a 32-bit instruction word and the values of both source operands. It returns the computed result, a flag that is high only for a recognised encoding, and the destination register index taken from the instruction.

The bit index is chosen in one of two ways:
- Register-shift forms take it from the low bits of the second operand value.
- Immediate forms take it from the shift-amount field of the instruction.

The 32-bit word forms work on the low half of the first operand. For these forms the unit limits the index to 0..31 and copies result bit 31 into the upper 32 bits. An encoding that the unit does not recognise raises no exception: the flag drops and the result reads zero.

Top module: `sbit_exec_unit`

## Requirements
- R1: Set returns rs1 with bit k forced to 1, where k is the effective bit index.
- R2: Clear returns rs1 with bit k forced to 0.
- R3: Invert returns rs1 with bit k toggled.
- R4: Extract returns bit k of rs1 in result bit 0, and all other result bits are 0.
- R5: With opcode 0110011, the register forms are recognised by funct7/funct3:
  - set 0010100/001
  - clear 0100100/001
  - invert 0110100/001
  - extract 0100100/101
- R6: With opcode 0010011, the immediate forms are recognised by instruction bits [31:26] and funct3:
  - set 001010/001
  - clear 010010/001
  - invert 011010/001
  - extract 010010/101

  Bits [25:20] form the 6-bit index.
- R7: In full-width register forms, k is rs2[5:0]. Higher rs2 bits have no effect.
- R8: The word forms limit the index to 5 bits:
  - Register-word (opcode 0111011, same funct7/funct3 as R5) uses rs2[4:0].
  - Immediate-word (opcode 0011011, funct7 as in R5, funct3 001) uses instr[24:20] and requires instr[25]=0.
- R9: Word forms copy bit 31 of the computed result into result bits [63:32].
- R10: Opcode 0011011 with funct3 101 (an extract-immediate-word pattern) is never recognised.
- R11: Any unrecognised encoding gives valid_o=0 and result_o=0. Any recognised encoding gives valid_o=1.
- R12: rd_o always equals instr[11:7], whether or not the encoding is recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| rs1_i | input | 64 | First source operand value |
| rs2_i | input | 64 | Second source operand value (index source for register forms) |
| result_o | output | 64 | Operation result, zero when not recognised |
| valid_o | output | 1 | High when the encoding is recognised |
| rd_o | output | 5 | Destination register index |

## Verification
The bench targets these corner cases:
- **Index 63 in full-width forms and index 31 in word forms.** If sign extension were missing or applied to the wrong bit, the upper word would be wrong. This is also where an index mask one bit too wide or too narrow shows up.
- **Index values of 32 and above sent to the word forms.** These expose a design that forgets to drop bit 5.
- **rs2 values with garbage above the index field.** These catch an index taken from too many bits.
- **Immediate encodings where instruction bit 25 is part of the index.** These catch a decoder that compares bit 25 as a funct bit, which would reject half the immediate indices.
- **The missing extract-immediate-word pattern and near-miss funct values.** A loose decoder would report these as valid with a non-zero result.

// File: rtl/sbit_pkg.sv
package sbit_pkg;

  typedef enum logic [1:0] {
    BOP_SET = 2'd0,
    BOP_CLR = 2'd1,
    BOP_INV = 2'd2,
    BOP_EXT = 2'd3
  } bop_e;

  typedef struct packed {
    logic hit;
    bop_e op;
    logic word;
    logic imm;
  } bdec_t;

  typedef struct packed {
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [6:0] care;
    bop_e       op;
    logic       word;
    logic       imm;
  } bpat_t;

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_REGW = 7'b0111011;
  localparam logic [6:0] OPC_IMMW = 7'b0011011;

  localparam logic [2:0] F3_MOD = 3'b001;
  localparam logic [2:0] F3_EXT = 3'b101;

  localparam logic [6:0] F7_SET = 7'b0010100;
  localparam logic [6:0] F7_CLR = 7'b0100100;
  localparam logic [6:0] F7_INV = 7'b0110100;

  localparam logic [6:0] CARE_ALL = 7'b1111111;
  localparam logic [6:0] CARE_SH6 = 7'b1111110;  // bit 25 is index

  localparam int NPAT = 15;

  localparam bpat_t PATS [NPAT] = '{
    '{OPC_REG,  F3_MOD, F7_SET, CARE_ALL, BOP_SET, 1'b0, 1'b0},
    '{OPC_REG,  F3_MOD, F7_CLR, CARE_ALL, BOP_CLR, 1'b0, 1'b0},
    '{OPC_REG,  F3_MOD, F7_INV, CARE_ALL, BOP_INV, 1'b0, 1'b0},
    '{OPC_REG,  F3_EXT, F7_CLR, CARE_ALL, BOP_EXT, 1'b0, 1'b0},
    '{OPC_IMM,  F3_MOD, F7_SET, CARE_SH6, BOP_SET, 1'b0, 1'b1},
    '{OPC_IMM,  F3_MOD, F7_CLR, CARE_SH6, BOP_CLR, 1'b0, 1'b1},
    '{OPC_IMM,  F3_MOD, F7_INV, CARE_SH6, BOP_INV, 1'b0, 1'b1},
    '{OPC_IMM,  F3_EXT, F7_CLR, CARE_SH6, BOP_EXT, 1'b0, 1'b1},
    '{OPC_REGW, F3_MOD, F7_SET, CARE_ALL, BOP_SET, 1'b1, 1'b0},
    '{OPC_REGW, F3_MOD, F7_CLR, CARE_ALL, BOP_CLR, 1'b1, 1'b0},
    '{OPC_REGW, F3_MOD, F7_INV, CARE_ALL, BOP_INV, 1'b1, 1'b0},
    '{OPC_REGW, F3_EXT, F7_CLR, CARE_ALL, BOP_EXT, 1'b1, 1'b0},
    '{OPC_IMMW, F3_MOD, F7_SET, CARE_ALL, BOP_SET, 1'b1, 1'b1},
    '{OPC_IMMW, F3_MOD, F7_CLR, CARE_ALL, BOP_CLR, 1'b1, 1'b1},
    '{OPC_IMMW, F3_MOD, F7_INV, CARE_ALL, BOP_INV, 1'b1, 1'b1}
  };

endpackage

// File: rtl/sbit_decode.sv
module sbit_decode
  import sbit_pkg::*;
(
  input  logic [31:0] instr_i,
  output bdec_t       dec_o
);

  logic [NPAT-1:0] hit;

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    assign hit[g] = (instr_i[6:0] == PATS[g].opc) &&
                    (instr_i[14:12] == PATS[g].f3) &&
                    (((instr_i[31:25] ^ PATS[g].f7) & PATS[g].care) == 7'd0);
  end

  // patterns are disjoint, so an OR-merge acts as a one-hot mux
  always_comb begin
    logic [1:0] op_acc;
    logic       word_acc;
    logic       imm_acc;
    op_acc   = '0;
    word_acc = 1'b0;
    imm_acc  = 1'b0;
    for (int i = 0; i < NPAT; i++) begin
      if (hit[i]) begin
        op_acc   = op_acc | PATS[i].op;
        word_acc = word_acc | PATS[i].word;
        imm_acc  = imm_acc | PATS[i].imm;
      end
    end
    dec_o.hit  = |hit;
    dec_o.op   = bop_e'(op_acc);
    dec_o.word = word_acc;
    dec_o.imm  = imm_acc;
  end

endmodule

// File: rtl/sbit_index.sv
module sbit_index
  import sbit_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int IDX_W  = $clog2(XLEN),
  localparam int WIDX_W = $clog2(WLEN)
) (
  input  logic [XLEN-1:0]  rs2_i,
  input  logic [IDX_W-1:0] imm_idx_i,
  input  bdec_t            dec_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] raw_idx;

  assign raw_idx = dec_i.imm ? imm_idx_i : rs2_i[IDX_W-1:0];

  always_comb begin
    if (dec_i.word) begin
      idx_o = '0;
      idx_o[WIDX_W-1:0] = raw_idx[WIDX_W-1:0];
    end else begin
      idx_o = raw_idx;
    end
  end

endmodule

// File: rtl/sbit_alu.sv
module sbit_alu
  import sbit_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [IDX_W-1:0] idx_i,
  input  bdec_t            dec_i,
  output logic [XLEN-1:0]  result_o
);

  logic [XLEN-1:0] bit_mask;
  logic [XLEN-1:0] raw_res;
  logic [XLEN-1:0] shr_val;

  assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << idx_i;
  assign shr_val  = rs1_i >> idx_i;

  always_comb begin
    unique case (dec_i.op)
      BOP_SET: raw_res = rs1_i | bit_mask;
      BOP_CLR: raw_res = rs1_i & ~bit_mask;
      BOP_INV: raw_res = rs1_i ^ bit_mask;
      default: raw_res = {{(XLEN-1){1'b0}}, shr_val[0]};
    endcase
  end

  always_comb begin
    if (!dec_i.hit)
      result_o = '0;
    else if (dec_i.word)
      result_o = {{(XLEN-WLEN){raw_res[WLEN-1]}}, raw_res[WLEN-1:0]};
    else
      result_o = raw_res;
  end

endmodule

// File: rtl/sbit_exec_unit.sv
module sbit_exec_unit
  import sbit_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o,
  output logic [4:0]      rd_o
);

  bdec_t            dec;
  logic [IDX_W-1:0] idx;

  sbit_decode i_decode (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  sbit_index #(.XLEN(XLEN), .WLEN(WLEN)) i_index (
    .rs2_i     (rs2_i),
    .imm_idx_i (instr_i[20 +: IDX_W]),
    .dec_i     (dec),
    .idx_o     (idx)
  );

  sbit_alu #(.XLEN(XLEN), .WLEN(WLEN)) i_alu (
    .rs1_i    (rs1_i),
    .idx_i    (idx),
    .dec_i    (dec),
    .result_o (result_o)
  );

  assign valid_o = dec.hit;
  assign rd_o    = instr_i[11:7];

endmodule

// File: rtl/sbit_exec_chk.sv
module sbit_exec_chk #(
  parameter int XLEN = 64
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] result_o,
  input logic            valid_o
);

  logic full_w;
  logic mod_f3;
  assign full_w = !instr_i[3];
  assign mod_f3 = instr_i[14:12] == 3'b001;

  always_comb begin
    // R11
    invalid_zero_chk: assert (valid_o || result_o == '0)
      else $error("result not zero on unrecognised encoding");
    // R10
    no_ext_immw_chk: assert (!(instr_i[6:0] == 7'b0011011 &&
                               instr_i[14:12] == 3'b101) || !valid_o)
      else $error("extract-immediate-word accepted");
    // R5
    reg_f3_chk: assert (!(instr_i[6:0] == 7'b0110011 &&
                          instr_i[14:12] != 3'b001 &&
                          instr_i[14:12] != 3'b101) || !valid_o)
      else $error("register form accepted with bad funct3");
    // R4
    ext_upper_zero_chk: assert (!(valid_o && instr_i[14:12] == 3'b101) ||
                                result_o[XLEN-1:1] == '0)
      else $error("extract upper bits not zero");
    // R9
    word_sext_chk: assert (!(valid_o && instr_i[3]) ||
                           result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}})
      else $error("word result not sign-extended");
    // R1
    set_only_adds_chk: assert (!(valid_o && full_w && mod_f3 &&
                                 instr_i[30:29] == 2'b01) ||
                               ((result_o & rs1_i) == rs1_i &&
                                $countones(result_o ^ rs1_i) <= 1))
      else $error("set changed more than one bit");
    // R2
    clr_only_drops_chk: assert (!(valid_o && full_w && mod_f3 &&
                                  instr_i[30:29] == 2'b10) ||
                                ((result_o | rs1_i) == rs1_i &&
                                 $countones(result_o ^ rs1_i) <= 1))
      else $error("clear changed more than one bit");
    // R3
    inv_one_bit_chk: assert (!(valid_o && full_w && mod_f3 &&
                               instr_i[30:29] == 2'b11) ||
                             $countones(result_o ^ rs1_i) == 1)
      else $error("invert did not toggle exactly one bit");
  end

endmodule

bind sbit_exec_unit sbit_exec_chk #(.XLEN(XLEN)) i_sbit_exec_chk (
  .instr_i  (instr_i),
  .rs1_i    (rs1_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/test_sbit_exec_unit.sv
module test_sbit_exec_unit;

  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr;
  logic [63:0] rs1, rs2, result;
  logic        valid;
  logic [4:0]  rd;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sbit_exec_unit i_sbit_exec_unit (
    .instr_i  (instr),
    .rs1_i    (rs1),
    .rs2_i    (rs2),
    .result_o (result),
    .valid_o  (valid),
    .rd_o     (rd)
  );

  // form: 0 reg, 1 imm, 2 reg-word, 3 imm-word; op: 0 set, 1 clr, 2 inv, 3 ext
  function automatic logic [31:0] build(input logic [1:0] form, input logic [1:0] op,
                                        input logic [5:0] idx, input logic [4:0] rdf);
    logic [6:0] f7;
    logic [2:0] f3;
    case (op)
      2'd0: f7 = 7'b0010100;
      2'd2: f7 = 7'b0110100;
      default: f7 = 7'b0100100;
    endcase
    f3 = (op == 2'd3) ? 3'b101 : 3'b001;
    case (form)
      2'd0: build = {f7, 5'd7, 5'd3, f3, rdf, 7'b0110011};
      2'd1: build = {f7[6:1], idx, 5'd3, f3, rdf, 7'b0010011};
      2'd2: build = {f7, 5'd7, 5'd3, f3, rdf, 7'b0111011};
      default: build = {f7, idx[4:0], 5'd3, f3, rdf, 7'b0011011};
    endcase
  endfunction

  function automatic logic [64:0] model(input logic [1:0] form, input logic [1:0] op,
                                        input logic [63:0] a, input logic [63:0] b,
                                        input logic [5:0] idx);
    int k;
    logic [63:0] r;
    if (form == 2'd3 && op == 2'd3) return {1'b0, 64'd0};
    case (form)
      2'd0: k = int'(b[5:0]);
      2'd1: k = int'(idx);
      2'd2: k = int'(b[4:0]);
      default: k = int'(idx[4:0]);
    endcase
    r = a;
    case (op)
      2'd0: r[k] = 1'b1;
      2'd1: r[k] = 1'b0;
      2'd2: r[k] = ~a[k];
      default: r = {63'd0, a[k]};
    endcase
    if (form[1]) r = {{32{r[31]}}, r[31:0]};
    return {1'b1, r};
  endfunction

  task automatic apply(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
    @(posedge clk);
    instr = i; rs1 = a; rs2 = b;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] er, input logic ev);
    n_chk++;
    if (result !== er || valid !== ev) begin
      n_bad++;
      $display("FAIL %s instr=%h: result=%h valid=%b expected result=%h valid=%b",
               req, instr, result, valid, er, ev);
    end
  endtask

  typedef struct packed {
    logic [1:0]  form;
    logic [1:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [5:0]  idx;
    logic [63:0] exp;
    logic        ev;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 64'h0, 64'd63, 6'd0, 64'h8000_0000_0000_0000, 1'b1},                // R1 R5
    '{2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1}, // R2
    '{2'd0, 2'd2, 64'h0, 64'hFFFF_FFFF_FFFF_FF45, 6'd0, 64'h20, 1'b1},                // R3 R7
    '{2'd0, 2'd3, 64'h8000_0000_0000_0000, 64'd63, 6'd0, 64'h1, 1'b1},                // R4
    '{2'd1, 2'd0, 64'h0, 64'd0, 6'd32, 64'h1_0000_0000, 1'b1},                        // R6
    '{2'd1, 2'd3, 64'h0000_0100_0000_0000, 64'd0, 6'd40, 64'h1, 1'b1},                // R6 R4
    '{2'd2, 2'd0, 64'h0, 64'd31, 6'd0, 64'hFFFF_FFFF_8000_0000, 1'b1},                // R9
    '{2'd2, 2'd0, 64'h0, 64'd63, 6'd0, 64'hFFFF_FFFF_8000_0000, 1'b1},                // R8
    '{2'd3, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd31, 64'h0000_0000_7FFF_FFFF, 1'b1}, // R9
    '{2'd2, 2'd2, 64'h1234_5678_0000_0000, 64'd0, 6'd0, 64'h1, 1'b1},                 // R9
    '{2'd2, 2'd3, 64'h8000_0000, 64'd31, 6'd0, 64'h1, 1'b1},                          // R8
    '{2'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd5, 64'h0, 1'b0}                  // R10
  };

  initial begin : watchdog
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [64:0] m;
    instr = 32'h0; rs1 = 64'hDEAD_BEEF_0000_FFFF; rs2 = '1;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 idle word recognised as nothing
    check("R11", 64'h0, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      apply(build(VECS[v].form, VECS[v].op, VECS[v].idx, 5'd9), VECS[v].a, VECS[v].b);
      check("R1-table", VECS[v].exp, VECS[v].ev);
    end

    // sweep R1 R2 R3 R4 R7 R8 R9 against model
    for (int f = 0; f < 4; f++) begin
      for (int o = 0; o < 4; o++) begin
        for (int k = 0; k < 64; k++) begin
          logic [63:0] a, b;
          a = {$urandom, $urandom};
          b = {$urandom, $urandom};
          b[5:0] = 6'(k);
          m = model(2'(f), 2'(o), a, b, 6'(k));
          apply(build(2'(f), 2'(o), 6'(k), 5'(k)), a, b);
          case (o)
            0: check("R1", m[63:0], m[64]);
            1: check("R2", m[63:0], m[64]);
            2: check("R3", m[63:0], m[64]);
            default: check("R4", m[63:0], m[64]);
          endcase
        end
      end
    end

    // R5 near misses
    apply({7'b0010100, 5'd7, 5'd3, 3'b010, 5'd1, 7'b0110011}, 64'h0, 64'd4);
    check("R5", 64'h0, 1'b0);
    apply({7'b0010101, 5'd7, 5'd3, 3'b001, 5'd1, 7'b0110011}, 64'h0, 64'd4);
    check("R5", 64'h0, 1'b0);
    apply({7'b0100100, 5'd7, 5'd3, 3'b101, 5'd1, 7'b0110011}, 64'h10, 64'hFFFF_FFFF_FFFF_FFC4);
    check("R7", 64'h1, 1'b1);
    // R6 wrong upper bits
    apply({6'b001011, 6'd4, 5'd3, 3'b001, 5'd1, 7'b0010011}, 64'h0, 64'd0);
    check("R6", 64'h0, 1'b0);
    // R8 imm-word with bit 25 set is not recognised
    apply({7'b0010101, 5'd4, 5'd3, 3'b001, 5'd1, 7'b0011011}, 64'h0, 64'd0);
    check("R8", 64'h0, 1'b0);
    // R10 extract-imm-word with extract funct7
    apply({7'b0100100, 5'd0, 5'd3, 3'b101, 5'd1, 7'b0011011}, 64'h1, 64'd0);
    check("R10", 64'h0, 1'b0);

    // R12 rd passthrough, valid and invalid
    for (int r = 0; r < 32; r += 7) begin
      apply(build(2'd0, 2'd0, 6'd0, 5'(r)), 64'h0, 64'd0);
      n_chk++;
      if (rd !== 5'(r)) begin
        n_bad++;
        $display("FAIL R12 rd=%0d expected %0d", rd, r);
      end
      apply({7'h7F, 5'd0, 5'd0, 3'b111, 5'(r), 7'b1111111}, 64'h0, 64'd0);
      n_chk++;
      if (rd !== 5'(r) || valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R12 rd=%0d valid=%b expected rd=%0d valid=0", rd, valid, r);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule